// File: doc/BRIEF.md
# Eight-Bit Arithmetic and Logic Unit with Flag Outputs

This block is the combinational datapath core of a small processor. It takes a left and a right operand and places one result on a shared output bus that other units also drive. A two-bit function code picks OR, AND, XOR or a binary sum. There are no dedicated subtract or add-with-carry codes. Instead, one control inverts every bit of the right operand, and a separate two-bit selector sets the carry into the adder to zero, one, or the carry bit held in an external status register. Sequencing logic combines these controls to form ADD, ADC and SUB.

The four condition flags (carry, zero, negative, overflow) are produced all the time, whatever the function code and whether or not the bus is driven. An external register decides when to capture them. When the output enable is low, the unit stops driving the bus and leaves it at high impedance.

Top module: `alu8_core`

## Requirements
- R1: Function code `op_sel` selects the bus result: 0 gives OR, 1 gives AND, 2 gives XOR and 3 gives the adder sum.
- R2: Carry-in code `cin_sel` sets the adder carry input: 0 forces it to 0, 1 forces it to 1, 2 takes `carry_stored`, and 3 forces it to 0.
- R3: When `inv_rhs` is 1, every bit of the right operand is complemented before it reaches both the logic functions and the adder. When `inv_rhs` is 0, the right operand passes through unchanged.
- R4: With `op_sel`=3, `inv_rhs`=1 and `cin_sel`=1 the result is left minus right modulo 256. With `cin_sel`=2 and `inv_rhs`=0 the result is left + right + `carry_stored`.
- R5: With `out_en`=0 the unit drives no bit of `z_bus` (high impedance). With `out_en`=1 it drives the selected result.
- R6: `flag_c` is the carry out of bit 7 of the adder. It is reported for every function code, including the logic ones.
- R7: `flag_v` is 1 exactly when the two adder inputs, taken after the optional inversion, have equal sign bits and the sum's sign bit differs from them. It is reported for every function code.
- R8: `flag_n` equals bit 7 of the selected result.
- R9: `flag_z` is 1 exactly when all eight bits of the selected result are 0. It is valid even while the bus is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| lhs | input | 8 | Left operand |
| rhs | input | 8 | Right operand |
| op_sel | input | 2 | Function code (0 OR, 1 AND, 2 XOR, 3 sum) |
| cin_sel | input | 2 | Carry-in source code |
| inv_rhs | input | 1 | Complement the right operand |
| carry_stored | input | 1 | Carry bit held in the status register |
| out_en | input | 1 | Drive the result onto the bus |
| z_bus | output | 8 | Tri-state result bus |
| flag_c | output | 1 | Carry out of the adder |
| flag_z | output | 1 | Result is zero |
| flag_n | output | 1 | Result sign bit |
| flag_v | output | 1 | Signed overflow of the adder |

## Verification
Whenever the bus is driven, the assertions check four relations on the ports: the negative and zero flags agree with the value on the bus, the overflow flag agrees with the operand signs, and for the sum code the carry and the bus together equal an independent reference sum. Some behaviours can only be shown by the bench's scenarios. These are the release of the bus, seen through a pull-up on the wired net, and zero-flag validity while the bus is released. They also include the carry-in code 3 aliasing to zero and flag reporting under the logic codes. The bench compares every output against a behavioural model over directed corner values and a long pseudo-random sweep.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

   typedef enum logic [1:0] {
      FN_OR  = 2'd0,
      FN_AND = 2'd1,
      FN_XOR = 2'd2,
      FN_SUM = 2'd3
   } alu_fn_e;

   typedef enum logic [1:0] {
      CI_ZERO  = 2'd0,
      CI_ONE   = 2'd1,
      CI_SAVED = 2'd2,
      CI_SPARE = 2'd3
   } alu_cin_e;

endpackage

// File: rtl/alu8_operand_stage.sv
module alu8_operand_stage #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] rhs_raw,
   input  logic             invert,
   input  logic [1:0]       cin_code,
   input  logic             carry_saved,
   output logic [WIDTH-1:0] rhs_eff,
   output logic             cin_eff
);
   import alu8_pkg::*;

   // the complement is a per-bit XOR with the control, shared by logic and adder paths
   for (genvar gi = 0; gi < WIDTH; gi++) begin : g_inv
      assign rhs_eff[gi] = rhs_raw[gi] ^ invert;
   end

   always_comb begin
      unique case (alu_cin_e'(cin_code))
         CI_ONE:   cin_eff = 1'b1;
         CI_SAVED: cin_eff = carry_saved;
         default:  cin_eff = 1'b0;
      endcase
   end

endmodule

// File: rtl/alu8_adder.sv
module alu8_adder #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic             c_in,
   output logic [WIDTH-1:0] sum,
   output logic             c_out
);

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] cy;
      assign cy[0] = c_in;
      for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
         logic hp;
         assign hp         = a_in[gi] ^ b_in[gi];
         assign sum[gi]    = hp ^ cy[gi];
         assign cy[gi + 1] = (a_in[gi] & b_in[gi]) | (hp & cy[gi]);
      end
      assign c_out = cy[WIDTH];
   end else begin : g_behav
      logic [WIDTH:0] wide;
      assign wide  = {1'b0, a_in} + {1'b0, b_in} + {{WIDTH{1'b0}}, c_in};
      assign sum   = wide[WIDTH-1:0];
      assign c_out = wide[WIDTH];
   end

endmodule

// File: rtl/alu8_result_mux.sv
module alu8_result_mux #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [WIDTH-1:0] sum,
   input  logic [1:0]       fn,
   output logic [WIDTH-1:0] res
);
   import alu8_pkg::*;

   for (genvar gi = 0; gi < WIDTH; gi++) begin : g_bit
      always_comb begin
         unique case (alu_fn_e'(fn))
            FN_OR:   res[gi] = a_in[gi] | b_in[gi];
            FN_AND:  res[gi] = a_in[gi] & b_in[gi];
            FN_XOR:  res[gi] = a_in[gi] ^ b_in[gi];
            default: res[gi] = sum[gi];
         endcase
      end
   end

endmodule

// File: rtl/alu8_flag_gen.sv
module alu8_flag_gen #(
   parameter int WIDTH = 8
) (
   input  logic [WIDTH-1:0] res,
   input  logic [WIDTH-1:0] a_in,
   input  logic [WIDTH-1:0] b_in,
   input  logic [WIDTH-1:0] sum,
   input  logic             c_out,
   output logic             fc,
   output logic             fz,
   output logic             fn,
   output logic             fv
);
   localparam int MSB = WIDTH - 1;

   assign fc = c_out;
   assign fz = ~|res;
   assign fn = res[MSB];
   // same-sign inputs, different-sign sum; taken from adder whatever the function code
   assign fv = ~(a_in[MSB] ^ b_in[MSB]) & (sum[MSB] ^ a_in[MSB]);

endmodule

// File: rtl/alu8_core.sv
module alu8_core #(
   parameter int WIDTH  = 8,
   parameter bit RIPPLE = 1'b1
) (
   input  logic [WIDTH-1:0] lhs,
   input  logic [WIDTH-1:0] rhs,
   input  logic [1:0]       op_sel,
   input  logic [1:0]       cin_sel,
   input  logic             inv_rhs,
   input  logic             carry_stored,
   input  logic             out_en,
   output wire  [WIDTH-1:0] z_bus,
   output logic             flag_c,
   output logic             flag_z,
   output logic             flag_n,
   output logic             flag_v
);

   if (WIDTH < 2) begin : g_bad_width
      $error("alu8_core: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] rhs_eff;
   logic             cin_eff;
   logic [WIDTH-1:0] sum;
   logic             c_out;
   logic [WIDTH-1:0] res;

   alu8_operand_stage #(.WIDTH(WIDTH)) u_opnd (
      .rhs_raw    (rhs),
      .invert     (inv_rhs),
      .cin_code   (cin_sel),
      .carry_saved(carry_stored),
      .rhs_eff    (rhs_eff),
      .cin_eff    (cin_eff)
   );

   alu8_adder #(.WIDTH(WIDTH), .RIPPLE(RIPPLE)) u_add (
      .a_in (lhs),
      .b_in (rhs_eff),
      .c_in (cin_eff),
      .sum  (sum),
      .c_out(c_out)
   );

   alu8_result_mux #(.WIDTH(WIDTH)) u_mux (
      .a_in(lhs),
      .b_in(rhs_eff),
      .sum (sum),
      .fn  (op_sel),
      .res (res)
   );

   alu8_flag_gen #(.WIDTH(WIDTH)) u_flags (
      .res  (res),
      .a_in (lhs),
      .b_in (rhs_eff),
      .sum  (sum),
      .c_out(c_out),
      .fc   (flag_c),
      .fz   (flag_z),
      .fn   (flag_n),
      .fv   (flag_v)
   );

   assign z_bus = out_en ? res : {WIDTH{1'bz}};

endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk #(
   parameter int WIDTH = 8
) (
   input logic [WIDTH-1:0] lhs,
   input logic [WIDTH-1:0] rhs,
   input logic [1:0]       op_sel,
   input logic [1:0]       cin_sel,
   input logic             inv_rhs,
   input logic             carry_stored,
   input logic             out_en,
   input logic [WIDTH-1:0] z_bus,
   input logic             flag_c,
   input logic             flag_z,
   input logic             flag_n,
   input logic             flag_v
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH:0]   ref_sum;
   logic [WIDTH-1:0] b_view;
   logic             ci_view;

   always_comb begin
      b_view  = inv_rhs ? ~rhs : rhs;
      ci_view = (cin_sel == 2'd1) ? 1'b1 : ((cin_sel == 2'd2) ? carry_stored : 1'b0);
      ref_sum = {1'b0, lhs} + {1'b0, b_view} + {{WIDTH{1'b0}}, ci_view};
   end

   always_comb begin
      if (out_en) begin
         a_r8_neg_is_bus_msb: assert (flag_n == z_bus[MSB])
            else $error("R8 negative flag disagrees with bus sign");
         a_r9_zero_matches_bus: assert (flag_z == (z_bus == '0))
            else $error("R9 zero flag disagrees with bus");
      end
      if (out_en && op_sel == 2'd3) begin
         a_r6_carry_and_sum: assert ({flag_c, z_bus} == ref_sum)
            else $error("R6 carry/sum disagree with reference");
      end
      if (flag_v) begin
         a_r7_overflow_same_sign: assert (lhs[MSB] == b_view[MSB])
            else $error("R7 overflow with operands of differing sign");
      end
   end

endmodule

bind alu8_core alu8_core_chk #(.WIDTH(WIDTH)) u_chk (.*);

// File: tb/alu8_core_test.sv
module alu8_core_test;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [7:0] lhs = 8'h00;
   logic [7:0] rhs = 8'h00;
   logic [1:0] op_sel = 2'd0;
   logic [1:0] cin_sel = 2'd0;
   logic       inv_rhs = 1'b0;
   logic       carry_stored = 1'b0;
   logic       out_en = 1'b0;
   wire  [7:0] bus_w;
   logic       flag_c, flag_z, flag_n, flag_v;

   int checks = 0;
   int errors = 0;
   int cycles = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   for (genvar gi = 0; gi < 8; gi++) begin : g_pu
      pullup pu_b (bus_w[gi]);
   end

   alu8_core uut (
      .lhs(lhs), .rhs(rhs), .op_sel(op_sel), .cin_sel(cin_sel),
      .inv_rhs(inv_rhs), .carry_stored(carry_stored), .out_en(out_en),
      .z_bus(bus_w), .flag_c(flag_c), .flag_z(flag_z),
      .flag_n(flag_n), .flag_v(flag_v)
   );

   // behavioural reference, integers only
   int e_bus, e_c, e_z, e_n, e_v;
   task automatic model();
      int b, ci, s, r;
      b  = inv_rhs ? (255 - int'(rhs)) : int'(rhs);
      ci = (cin_sel == 2'd1) ? 1 : ((cin_sel == 2'd2) ? int'(carry_stored) : 0);
      s  = int'(lhs) + b + ci;
      case (op_sel)
         2'd0: r = int'(lhs) | b;
         2'd1: r = int'(lhs) & b;
         2'd2: r = int'(lhs) ^ b;
         default: r = s % 256;
      endcase
      e_c   = s / 256;
      e_z   = (r == 0) ? 1 : 0;
      e_n   = r / 128;
      e_v   = (((int'(lhs) / 128) == (b / 128)) && (((s % 256) / 128) != (int'(lhs) / 128))) ? 1 : 0;
      e_bus = out_en ? r : 255;
   endtask

   task automatic chk(string tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h (lhs=%0h rhs=%0h op=%0d ci=%0d inv=%0d cs=%0d oe=%0d)",
                  tag, act, exp, lhs, rhs, op_sel, cin_sel, inv_rhs, carry_stored, out_en);
      end
   endtask

   // drive after a rising edge, compare at the falling edge
   task automatic apply(string tag, logic [7:0] a, logic [7:0] b, logic [1:0] op,
                        logic [1:0] ci, logic inv, logic cs, logic oe);
      @(posedge clk);
      lhs = a; rhs = b; op_sel = op; cin_sel = ci; inv_rhs = inv; carry_stored = cs; out_en = oe;
      @(negedge clk);
      model();
      chk({tag, " bus (R1/R5)"}, int'(bus_w), e_bus);
      chk({tag, " R6 carry"}, int'(flag_c), e_c);
      chk({tag, " R9 zero"}, int'(flag_z), e_z);
      chk({tag, " R8 neg"}, int'(flag_n), e_n);
      chk({tag, " R7 ovf"}, int'(flag_v), e_v);
   endtask

   initial begin
      logic [15:0] lfsr = 16'hACE1;
      repeat (3) @(posedge clk);
      rst = 1'b0;
      @(negedge clk);
      // R5: idle state, bus released so the pull-up is seen
      chk("R5 idle bus released", int'(bus_w), 255);
      // R1 function codes
      apply("R1 or",  8'hA5, 8'h0F, 2'd0, 2'd0, 1'b0, 1'b0, 1'b1);
      apply("R1 and", 8'hA5, 8'h0F, 2'd1, 2'd0, 1'b0, 1'b0, 1'b1);
      apply("R1 xor", 8'hA5, 8'h0F, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1);
      apply("R1 add", 8'h12, 8'h34, 2'd3, 2'd0, 1'b0, 1'b1, 1'b1);
      // R2 carry-in codes, with stored carry both ways
      apply("R2 ci0", 8'h10, 8'h01, 2'd3, 2'd0, 1'b0, 1'b1, 1'b1);
      apply("R2 ci1", 8'h10, 8'h01, 2'd3, 2'd1, 1'b0, 1'b0, 1'b1);
      apply("R2 ci2 set", 8'h10, 8'h01, 2'd3, 2'd2, 1'b0, 1'b1, 1'b1);
      apply("R2 ci2 clr", 8'h10, 8'h01, 2'd3, 2'd2, 1'b0, 1'b0, 1'b1);
      apply("R2 ci3 zero", 8'h10, 8'h01, 2'd3, 2'd3, 1'b0, 1'b1, 1'b1);
      // R3 inversion into the logic path
      apply("R3 and inv", 8'hF0, 8'h3C, 2'd1, 2'd0, 1'b1, 1'b0, 1'b1);
      apply("R3 or inv",  8'h00, 8'h3C, 2'd0, 2'd0, 1'b1, 1'b0, 1'b1);
      // R4 subtract and add-with-carry
      apply("R4 sub", 8'h50, 8'h20, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1);
      apply("R4 sub borrow", 8'h20, 8'h50, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1);
      apply("R4 sub equal", 8'h77, 8'h77, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1);
      apply("R4 adc", 8'hFF, 8'h00, 2'd3, 2'd2, 1'b0, 1'b1, 1'b1);
      // R7 overflow corners
      apply("R7 pos+pos", 8'h7F, 8'h01, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
      apply("R7 neg+neg", 8'h80, 8'h80, 2'd3, 2'd0, 1'b0, 1'b0, 1'b1);
      apply("R7 sub ovf", 8'h80, 8'h01, 2'd3, 2'd1, 1'b1, 1'b0, 1'b1);
      // R6/R7 flags under a logic code
      apply("R6 flags on xor", 8'hC0, 8'h80, 2'd2, 2'd0, 1'b0, 1'b0, 1'b1);
      // R5/R9 released bus, zero flag still valid
      apply("R9 released zero", 8'h0F, 8'hF0, 2'd1, 2'd0, 1'b0, 1'b0, 1'b0);
      apply("R5 released sum", 8'h01, 8'h02, 2'd3, 2'd0, 1'b0, 1'b0, 1'b0);
      // pseudo-random sweep
      for (int k = 0; k < 2000; k++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         apply("rand", lfsr[7:0], lfsr[15:8], lfsr[1:0], lfsr[3:2], lfsr[4], lfsr[5],
               lfsr[6] | lfsr[9]);
      end
      done = 1'b1;
   end

   initial begin
      while (!done && cycles < 20000) begin
         @(posedge clk);
         cycles++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      end
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule